// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Almost Flags

This block is a single-clock first-in first-out store of 4096 words, 12 bits each, with active-low write and read enables. Besides full and empty it raises two programmable warnings. Almost-empty is raised while the stored word count is at or below one threshold. Almost-full is raised while the free space is at or below a second threshold. Both thresholds are loaded from the data input bus. Driving the load strobe low stores the bus into the threshold register chosen by a select bit, and no FIFO write happens in that cycle.

The write pointer and the read pointer each have their own active-low clear. Each clear returns only its own pointer to location 0, so a stored line can be written again or read again without disturbing the other side. After such a clear the occupancy is recomputed from the gap between the two pointers. A system reset clears both pointers and both thresholds.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rstN` is low, both pointers, both thresholds and `dataOut` clear to zero. After reset, `emptyFlag` and `almostEmptyFlag` read 1 and `fullFlag` and `almostFullFlag` read 0.
- R2: Words come out in the order they were written. A read is accepted when `rdEnN` is 0, `rdPtrRstN` is 1 and the FIFO is not empty. The word read appears on `dataOut` right after the clock edge that accepts the read, and `dataOut` holds its value in every other cycle.
- R3: A write attempt while `fullFlag` is 1 is ignored. No word is stored, the write pointer does not move, and a read in the same cycle is still accepted.
- R4: A read attempt while `emptyFlag` is 1 is ignored. `dataOut` holds its value and the read pointer does not move.
- R5: `fullFlag` is 1 exactly when 4096 words are stored. `emptyFlag` is 1 exactly when none are stored. Every flag is registered and reflects the state after the same clock edge that changed it.
- R6: When `loadN` is 0, `dataIn` is stored into the almost-empty threshold if `thrSel` is 0, or into the almost-full threshold if `thrSel` is 1. `dataIn` bit 0 maps to the threshold LSB and bit 11 to its MSB. No FIFO write happens in a load cycle.
- R7: `almostEmptyFlag` is 1 when the stored count is less than or equal to the almost-empty threshold.
- R8: `almostFullFlag` is 1 when 4096 minus the stored count is less than or equal to the almost-full threshold.
- R9: When `wrPtrRstN` is 0, the write pointer returns to location 0. No word is written in that cycle, and the read pointer is unaffected.
- R10: When `rdPtrRstN` is 0, the read pointer returns to location 0. No read happens in that cycle, `dataOut` holds, and the write pointer is unaffected.
- R11: In any cycle with a pointer clear, the count becomes (write pointer − read pointer) modulo 4096, taken after the edge. Equal pointers mean empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low system reset |
| wrEnN | input | 1 | Active-low write enable |
| rdEnN | input | 1 | Active-low read enable |
| loadN | input | 1 | Active-low threshold load strobe |
| thrSel | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| wrPtrRstN | input | 1 | Active-low write pointer clear |
| rdPtrRstN | input | 1 | Active-low read pointer clear |
| dataIn | input | 12 | Write data and threshold load value |
| dataOut | output | 12 | Registered read data |
| fullFlag | output | 1 | 4096 words stored |
| emptyFlag | output | 1 | No word stored |
| almostFullFlag | output | 1 | Free space at or below almost-full threshold |
| almostEmptyFlag | output | 1 | Count at or below almost-empty threshold |

## Verification
Every result of this block is due one clock edge after the stimulus. That includes read data, all four flags, threshold loads and pointer clears, and there is no longer pipeline anywhere. The bench drives each stimulus at a falling edge, advances its model at the next rising edge, and compares all five outputs at the following falling edge. Each step therefore sees exactly the state that edge produced. Pointer clears are checked through later reads and flags rather than internal state.

// File: rtl/pff_pkg.sv
package pff_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;   // accepted write this cycle
    logic rdStrobe;   // accepted read this cycle
    logic wrClr;      // write pointer to location 0
    logic rdClr;      // read pointer to location 0
  } pff_ctl_t;
endpackage

// File: rtl/pff_thresh.sv
module pff_thresh #(
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             thrSel,
  input  logic [THR_W-1:0] dataIn,
  output logic [THR_W-1:0] aeThrNext,
  output logic [THR_W-1:0] afThrNext
);
  localparam int NUM_THR = 2;  // index 0 almost-empty, 1 almost-full

  logic [THR_W-1:0] thrQ [NUM_THR];
  logic [THR_W-1:0] thrD [NUM_THR];

  for (genvar g = 0; g < NUM_THR; g++) begin : gThr
    always_comb begin
      thrD[g] = thrQ[g];
      if (!loadN && (thrSel == 1'(g))) thrD[g] = dataIn;
    end
    always_ff @(posedge clk) begin
      if (!rstN) thrQ[g] <= '0;
      else       thrQ[g] <= thrD[g];
    end
  end

  assign aeThrNext = thrD[0];
  assign afThrNext = thrD[1];

  // R6: thresholds change only in load cycles, and only the selected one
  assert_thr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> ($stable(thrQ[0]) && $stable(thrQ[1])));
  assert_sel_af_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && thrSel) |=> $stable(thrQ[0]));
  assert_sel_ae_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !thrSel) |=> $stable(thrQ[1]));
endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl
  import pff_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int THR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              loadN,
  input  logic              wrPtrRstN,
  input  logic              rdPtrRstN,
  input  logic [ADDR_W-1:0] wrPtrNext,
  input  logic [ADDR_W-1:0] rdPtrNext,
  input  logic [THR_W-1:0]  aeThrNext,
  input  logic [THR_W-1:0]  afThrNext,
  output pff_ctl_t          ctl,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic              almostFullFlag,
  output logic              almostEmptyFlag
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

  logic [CNT_W-1:0]  count, countNext, freeNext;
  logic [ADDR_W-1:0] ptrGap;

  // strobes from registered flags and port controls only
  always_comb begin
    ctl.wrStrobe = !wrEnN && loadN && wrPtrRstN && !fullFlag;
    ctl.rdStrobe = !rdEnN && rdPtrRstN && !emptyFlag;
    ctl.wrClr    = !wrPtrRstN;
    ctl.rdClr    = !rdPtrRstN;
  end

  assign ptrGap = wrPtrNext - rdPtrNext;

  always_comb begin
    if (ctl.wrClr || ctl.rdClr)
      countNext = {1'b0, ptrGap};
    else
      countNext = count + CNT_W'(ctl.wrStrobe) - CNT_W'(ctl.rdStrobe);
    freeNext = DEPTH - countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count           <= '0;
      fullFlag        <= 1'b0;
      emptyFlag       <= 1'b1;
      almostFullFlag  <= 1'b0;
      almostEmptyFlag <= 1'b1;
    end else begin
      count           <= countNext;
      fullFlag        <= (countNext == DEPTH);
      emptyFlag       <= (countNext == '0);
      almostFullFlag  <= (freeNext  <= CNT_W'(afThrNext));
      almostEmptyFlag <= (countNext <= CNT_W'(aeThrNext));
    end
  end

  assert_full_empty_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(fullFlag && emptyFlag));
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH);
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtrRstN && rdPtrRstN) |=>
      ((count == $past(count)) || (count == $past(count) + 1'b1) ||
       (count + 1'b1 == $past(count))));
  assert_empty_implies_ae_R7: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> almostEmptyFlag);
  assert_full_implies_af_R8: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> almostFullFlag);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && rdEnN && wrPtrRstN && rdPtrRstN) |=> fullFlag);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && (wrEnN || !loadN) && wrPtrRstN && rdPtrRstN) |=> emptyFlag);
  assert_both_clear_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPtrRstN && !rdPtrRstN) |=> emptyFlag);
endmodule

// File: rtl/pff_dpath.sv
module pff_dpath
  import pff_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  pff_ctl_t          ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] wrPtrNext,
  output logic [ADDR_W-1:0] rdPtrNext,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  always_comb begin
    wrPtrNext = ctl.wrClr ? '0 : wrPtr + ADDR_W'(ctl.wrStrobe);
    rdPtrNext = ctl.rdClr ? '0 : rdPtr + ADDR_W'(ctl.rdStrobe);
  end

  always_ff @(posedge clk) begin
    if (ctl.wrStrobe) mem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      dataOut <= '0;
    end else begin
      wrPtr <= wrPtrNext;
      rdPtr <= rdPtrNext;
      if (ctl.rdStrobe) dataOut <= mem[rdPtr];
    end
  end

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdStrobe |=> $stable(dataOut));
  assert_rdclr_keeps_wr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdClr && !ctl.wrStrobe && !ctl.wrClr) |=> $stable(wrPtr));
  assert_wrclr_keeps_rd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrClr && !ctl.rdStrobe && !ctl.rdClr) |=> $stable(rdPtr));
  assert_rdclr_out_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdClr |=> $stable(dataOut));
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              loadN,
  input  logic              thrSel,
  input  logic              wrPtrRstN,
  input  logic              rdPtrRstN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic              almostFullFlag,
  output logic              almostEmptyFlag
);
  pff_ctl_t          ctl;
  logic [ADDR_W-1:0] wrPtrNext, rdPtrNext;
  logic [DATA_W-1:0] aeThrNext, afThrNext;

  pff_thresh #(.THR_W(DATA_W)) thresh_i (
    .clk(clk), .rstN(rstN), .loadN(loadN), .thrSel(thrSel), .dataIn(dataIn),
    .aeThrNext(aeThrNext), .afThrNext(afThrNext)
  );

  pff_ctrl #(.ADDR_W(ADDR_W), .THR_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN),
    .wrPtrRstN(wrPtrRstN), .rdPtrRstN(rdPtrRstN),
    .wrPtrNext(wrPtrNext), .rdPtrNext(rdPtrNext),
    .aeThrNext(aeThrNext), .afThrNext(afThrNext), .ctl(ctl),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag),
    .almostFullFlag(almostFullFlag), .almostEmptyFlag(almostEmptyFlag)
  );

  pff_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .wrPtrNext(wrPtrNext), .rdPtrNext(rdPtrNext), .dataOut(dataOut)
  );
endmodule

// File: tb/prog_flag_fifo_tb_top.sv
module prog_flag_fifo_tb_top;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  logic rstN, wrEnN, rdEnN, loadN, thrSel, wrPtrRstN, rdPtrRstN;
  logic [11:0] dataIn, dataOut;
  logic fullFlag, emptyFlag, almostFullFlag, almostEmptyFlag;

  int checks = 0;
  int errors = 0;

  // requirement-level model
  int mMem [DEPTH];
  int mWr = 0, mRd = 0, mCnt = 0, mAe = 0, mAf = 0, mOut = 0;

  always #2 clk = ~clk;  // 250 MHz

  prog_flag_fifo dut_i (
    .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN),
    .thrSel(thrSel), .wrPtrRstN(wrPtrRstN), .rdPtrRstN(rdPtrRstN),
    .dataIn(dataIn), .dataOut(dataOut), .fullFlag(fullFlag),
    .emptyFlag(emptyFlag), .almostFullFlag(almostFullFlag),
    .almostEmptyFlag(almostEmptyFlag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk(tag, "dataOut", 32'(dataOut), 32'(mOut));
    chk(tag, "emptyFlag (R5)", 32'(emptyFlag), 32'(mCnt == 0));
    chk(tag, "fullFlag (R5)", 32'(fullFlag), 32'(mCnt == DEPTH));
    chk(tag, "almostEmptyFlag (R7)", 32'(almostEmptyFlag), 32'(mCnt <= mAe));
    chk(tag, "almostFullFlag (R8)", 32'(almostFullFlag), 32'((DEPTH - mCnt) <= mAf));
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input logic wE, input logic rE, input logic ld,
                      input logic sel, input logic wR, input logic rR,
                      input logic [11:0] d, input string tag);
    bit wa, ra;
    int nW, nR;
    wrEnN = wE; rdEnN = rE; loadN = ld; thrSel = sel;
    wrPtrRstN = wR; rdPtrRstN = rR; dataIn = d;
    @(posedge clk);
    wa = !wE && ld && wR && (mCnt != DEPTH);
    ra = !rE && rR && (mCnt != 0);
    if (!ld) begin
      if (sel) mAf = int'(d);
      else     mAe = int'(d);
    end
    if (ra) mOut = mMem[mRd];
    if (wa) mMem[mWr] = int'(d);
    nW = wR ? (mWr + int'(wa)) % DEPTH : 0;
    nR = rR ? (mRd + int'(ra)) % DEPTH : 0;
    if (!wR || !rR) mCnt = (nW - nR + DEPTH) % DEPTH;
    else            mCnt = mCnt + int'(wa) - int'(ra);
    mWr = nW; mRd = nR;
    @(negedge clk);
    wrEnN = 1; rdEnN = 1; loadN = 1; wrPtrRstN = 1; rdPtrRstN = 1;
    chkAll(tag);
  endtask

  task automatic wr(input logic [11:0] d, input string tag);
    step(0, 1, 1, 0, 1, 1, d, tag);
  endtask
  task automatic rd(input string tag);
    step(1, 0, 1, 0, 1, 1, 12'h0, tag);
  endtask
  task automatic wrrd(input logic [11:0] d, input string tag);
    step(0, 0, 1, 0, 1, 1, d, tag);
  endtask

  task automatic testReset();
    chk("R1", "dataOut", 32'(dataOut), 0);
    chk("R1", "emptyFlag", 32'(emptyFlag), 1);
    chk("R1", "almostEmptyFlag", 32'(almostEmptyFlag), 1);
    chk("R1", "fullFlag", 32'(fullFlag), 0);
    chk("R1", "almostFullFlag", 32'(almostFullFlag), 0);
  endtask

  task automatic testLoad();
    // load with write enable also low: no FIFO write
    step(0, 1, 0, 0, 1, 1, 12'h003, "R6");
    step(0, 1, 0, 1, 1, 1, 12'h002, "R6");
    chk("R6", "empty after load cycles", 32'(emptyFlag), 1);
    for (int i = 0; i < 4; i++) wr(12'h300 + 12'(i), "R7");
    chk("R7", "ae off at count 4 thr 3", 32'(almostEmptyFlag), 0);
    rd("R7");
    chk("R7", "ae on at count 3 thr 3", 32'(almostEmptyFlag), 1);
  endtask

  task automatic testOrder();
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) wrrd(12'hA00 + 12'(i), "R2");
      else            wr(12'hA00 + 12'(i), "R2");
    end
    while (mCnt > 0) rd("R2");
  endtask

  task automatic testEmptyRead();
    for (int i = 0; i < 3; i++) rd("R4");
    wrrd(12'h5A5, "R4");  // read refused on empty, write accepted
    chk("R4", "dataOut held on empty read", 32'(dataOut), 32'(mOut));
    rd("R2");
    chk("R2", "read after refused read", 32'(dataOut), 32'h5A5);
  endtask

  task automatic testFull();
    int n = 0;
    while (mCnt < DEPTH) begin
      wr(12'(n * 7 + 1), "R8");
      n++;
    end
    chk("R5", "full after 4096 writes", 32'(fullFlag), 1);
    for (int i = 0; i < 3; i++) wr(12'hFFF, "R3");
    wrrd(12'hEEE, "R3");  // read taken, write refused
    chk("R3", "first word out", 32'(dataOut), 32'(12'(1)));
    while (mCnt > 0) rd("R3");
  endtask

  task automatic testPtrReset();
    step(1, 1, 1, 0, 0, 0, 12'h0, "R11");
    for (int i = 0; i < 10; i++) wr(12'h100 + 12'(i), "R11");
    for (int i = 0; i < 4; i++) rd("R10");
    step(1, 0, 1, 0, 1, 0, 12'h0, "R10");  // clear read ptr, read ignored
    chk("R10", "dataOut held on clear", 32'(dataOut), 32'h103);
    rd("R10");
    chk("R10", "reread from location 0", 32'(dataOut), 32'h100);
    step(0, 1, 1, 0, 0, 1, 12'hBAD, "R9");  // clear write ptr, write ignored
    chk("R11", "count wraps to 4095", 32'(almostFullFlag), 1);
    rd("R9");
    chk("R9", "read ptr untouched", 32'(dataOut), 32'h101);
    wr(12'h222, "R9");
    step(1, 1, 1, 0, 1, 0, 12'h0, "R11");  // pointers now 1 and 0
    chk("R11", "one word after clear", 32'(emptyFlag), 0);
    rd("R9");
    chk("R9", "rewritten location 0", 32'(dataOut), 32'h222);
    chk("R11", "empty after catching up", 32'(emptyFlag), 1);
  endtask

  initial begin
    rstN = 0; wrEnN = 1; rdEnN = 1; loadN = 1; thrSel = 0;
    wrPtrRstN = 1; rdPtrRstN = 1; dataIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLoad();
    testOrder();
    testEmptyRead();
    testFull();
    testPtrReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule